// File: doc/BRIEF.md
# Ternary Match Table with Priority Select

This block is an associative lookup table. It holds a set of entries, and each entry has a stored word, a per-bit don't-care mask and a valid flag. A search presents a key. The block compares that key against every entry in the same cycle and reports three things: whether any entry agreed, the index of the lowest-numbered entry that agreed, and the full vector of per-entry agreement.

Software fills entries through an indexed write port. A mask bit of one makes that bit position irrelevant to the comparison. An entry with a zero mask therefore acts as an exact-match word. To get a longest-prefix lookup, software places the more specific prefixes (fewer masked bits) at lower indices. The block does not reorder entries, so the lowest-index rule then selects the longest prefix.

Top module: `tcam_lookup`

## Requirements
- R1: After reset every entry is invalid, and a search returns hit_o=0, idx_o=0 and match_o all zero.
- R2: A bit position matches when the stored bit equals the key bit. An entry matches only when every unmasked position matches.
- R3: A bit whose mask bit is 1 matches for any stored and key value. An entry with an all-ones mask matches every key.
- R4: An entry written with valid=0 never matches, whatever its data and mask.
- R5: match_o bit i is 1 exactly when valid entry i matches the key. All entries are evaluated in the same search.
- R6: When several entries match, idx_o is the lowest matching index and hit_o is 1.
- R7: When no entry matches, hit_o is 0 and idx_o is 0.
- R8: The outputs are registered. They update on the clock edge where srch_i is 1 and hold their value while srch_i is 0.
- R9: A search in the same cycle as a write sees the table contents from before that write.
- R10: A write with wr_en_i=1 replaces the data, mask and valid of the entry at wr_idx_i and leaves all other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_idx_i | input | IW | Index of the entry to write |
| wr_data_i | input | W | Stored word |
| wr_mask_i | input | W | Don't-care mask (1 = ignore bit) |
| wr_valid_i | input | 1 | Valid flag for the written entry |
| srch_i | input | 1 | Search strobe |
| key_i | input | W | Search key |
| hit_o | output | 1 | Registered: some entry matched |
| idx_o | output | IW | Registered: lowest matching index, or 0 |
| match_o | output | N | Registered: per-entry match vector |

## Verification
The hardest situations to reach from the ports are two: several overlapping masked entries matching at once, where only the lowest one may win, and a search that lands in the same cycle as a write. The bench uses a small configuration (8 entries, 4 bits) and keeps a model of the table. For the priority case it loads every entry with random ternary contents and then searches all 16 keys. It also walks a single catch-all entry across every index and places a specific entry above and below it. For the collision case it writes and searches on one edge, and the model applies the write only after it has computed the expected result.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  function automatic int unsigned clog2_min1(input int unsigned v);
    int unsigned r;
    r = 0;
    while ((1 << r) < v) r++;
    return (r == 0) ? 1 : r;
  endfunction
endpackage

// File: rtl/tcam_entry.sv
module tcam_entry #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  input  logic         valid_i,
  input  logic [W-1:0] key_i,
  output logic         match_o
);
  logic [W-1:0] data_q, mask_q;
  logic         valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      mask_q  <= '0;
      valid_q <= 1'b0;
    end else if (we_i) begin
      data_q  <= data_i;
      mask_q  <= mask_i;
      valid_q <= valid_i;
    end
  end

  // per-bit disagreement, cleared by mask
  logic [W-1:0] miss;
  assign miss    = (data_q ^ key_i) & ~mask_q;
  assign match_o = valid_q & ~(|miss);
endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    // descending scan so the lowest index wins
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup #(
  parameter int N  = 16,
  parameter int W  = 32,
  parameter int IW = tcam_pkg::clog2_min1(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [W-1:0]  wr_mask_i,
  input  logic          wr_valid_i,
  input  logic          srch_i,
  input  logic [W-1:0]  key_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  match_o
);
  logic [N-1:0] match_c;

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic we;
    assign we = wr_en_i && (wr_idx_i == IW'(g));
    tcam_entry #(.W(W)) u_ent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we),
      .data_i  (wr_data_i),
      .mask_i  (wr_mask_i),
      .valid_i (wr_valid_i),
      .key_i   (key_i),
      .match_o (match_c[g])
    );
  end

  logic          any_c;
  logic [IW-1:0] idx_c;

  tcam_prio_enc #(.N(N), .IW(IW)) u_enc (
    .req_i (match_c),
    .any_o (any_c),
    .idx_o (idx_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o   <= 1'b0;
      idx_o   <= '0;
      match_o <= '0;
    end else if (srch_i) begin
      hit_o   <= any_c;
      idx_o   <= idx_c;
      match_o <= match_c;
    end
  end
endmodule

// File: rtl/tcam_lookup_chk.sv
module tcam_lookup_chk #(
  parameter int N  = 16,
  parameter int IW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          srch_i,
  input logic          hit_o,
  input logic [IW-1:0] idx_o,
  input logic [N-1:0]  match_o
);
  // R7
  a_r7_miss_idx_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> idx_o == '0);
  // R5 / R6
  a_r6_hit_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (|match_o));
  // R6
  a_r6_idx_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> match_o[idx_o]);
  // R6
  a_r6_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_o & ((N'(1) << idx_o) - N'(1))) == '0));
  // R8
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !srch_i |=> $stable(match_o) && $stable(idx_o) && $stable(hit_o));
endmodule

bind tcam_lookup tcam_lookup_chk #(.N(N), .IW(IW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .srch_i  (srch_i),
  .hit_o   (hit_o),
  .idx_o   (idx_o),
  .match_o (match_o)
);

// File: tb/tb_tcam_lookup.sv
`timescale 1ns/1ps
module tb_tcam_lookup;
  localparam int N = 8, W = 4, IW = 3;

  logic          clk = 0, rst_ni = 0;
  logic          wr_en = 0, wr_valid = 0, srch = 0;
  logic [IW-1:0] wr_idx = '0;
  logic [W-1:0]  wr_data = '0, wr_mask = '0, key = '0;
  logic          hit;
  logic [IW-1:0] idx;
  logic [N-1:0]  mv;

  int errs = 0, chks = 0;
  logic [W-1:0] m_d [N];
  logic [W-1:0] m_m [N];
  logic         m_v [N];

  always #10 clk = ~clk;

  tcam_lookup #(.N(N), .W(W), .IW(IW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .wr_mask_i(wr_mask), .wr_valid_i(wr_valid),
    .srch_i(srch), .key_i(key), .hit_o(hit), .idx_o(idx), .match_o(mv));

  initial begin
    #4_000_000;
    errs++; chks++;
    $display("FAIL watchdog: run did not finish (got timeout, expected completion)");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  function automatic logic [N-1:0] exp_vec(input logic [W-1:0] k);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++)
      v[i] = m_v[i] && (((m_d[i] ^ k) & ~m_m[i]) == '0);
    return v;
  endfunction

  task automatic check(input string req, input logic [N-1:0] ev);
    logic          eh;
    logic [IW-1:0] ei;
    eh = |ev; ei = '0;
    for (int i = N - 1; i >= 0; i--) if (ev[i]) ei = IW'(i);
    chks++;
    if (hit !== eh || idx !== ei || mv !== ev) begin
      errs++;
      $display("FAIL %s: got hit=%b idx=%0d vec=%b, expected hit=%b idx=%0d vec=%b",
               req, hit, idx, mv, eh, ei, ev);
    end
  endtask

  task automatic wr(input int i, input logic [W-1:0] d, input logic [W-1:0] m, input logic v);
    @(negedge clk);
    wr_en = 1; wr_idx = IW'(i); wr_data = d; wr_mask = m; wr_valid = v;
    @(negedge clk);
    wr_en = 0;
    m_d[i] = d; m_m[i] = m; m_v[i] = v;
  endtask

  task automatic search(input logic [W-1:0] k, input string req);
    @(negedge clk);
    srch = 1; key = k;
    @(negedge clk);
    srch = 0;
    check(req, exp_vec(k));
  endtask

  task automatic clear_all();
    for (int i = 0; i < N; i++) wr(i, '0, '0, 0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_d[i] = '0; m_m[i] = '0; m_v[i] = 0; end
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    check("R1 reset state", '0);
    for (int k = 0; k < 16; k++) search(W'(k), "R1 empty table");

    // R2 exact match, all entries zero mask
    for (int i = 0; i < N; i++) wr(i, W'(i), '0, 1);
    for (int k = 0; k < 16; k++) search(W'(k), "R2 exact match");
    // R5 duplicates match in parallel
    wr(5, 4'h3, '0, 1);
    search(4'h3, "R5 duplicate vector");

    // R3 masks: catch-all walked over every index, with a specific entry around it
    for (int p = 0; p < N; p++) begin
      clear_all();
      wr(p, 4'h0, 4'hF, 1);
      wr((p + 3) % N, 4'hA, 4'h0, 1);
      for (int k = 0; k < 16; k++) search(W'(k), "R3 R6 catch-all priority");
    end

    // R4 invalid entries never match, even with full mask
    clear_all();
    wr(2, 4'h0, 4'hF, 0);
    wr(6, 4'h5, 4'h0, 0);
    search(4'h5, "R4 invalid entry");
    search(4'h0, "R4 invalid entry");

    // R6 prefix ordering: longer prefix at lower index
    clear_all();
    wr(0, 4'b1010, 4'b0000, 1);
    wr(1, 4'b1000, 4'b0011, 1);
    wr(2, 4'b1000, 4'b0111, 1);
    wr(3, 4'b0000, 4'b1111, 1);
    for (int k = 0; k < 16; k++) search(W'(k), "R6 longest prefix");
    // R7 no match
    wr(3, 4'h0, 4'h0, 1);
    search(4'b0111, "R7 miss");

    // R2/R3/R6 random ternary sweeps
    for (int r = 0; r < 20; r++) begin
      for (int i = 0; i < N; i++)
        wr(i, W'($urandom), W'($urandom) & W'($urandom), ($urandom % 4) != 0);
      for (int k = 0; k < 16; k++) search(W'(k), "R2 R3 R6 random sweep");
    end

    // R8 hold while strobe low
    clear_all();
    wr(1, 4'h9, 4'h0, 1);
    search(4'h9, "R8 before hold");
    @(negedge clk); key = 4'h0;
    repeat (3) @(negedge clk);
    check("R8 hold with srch low", 8'b0000_0010);

    // R9 search and write on the same edge: old contents seen
    @(negedge clk);
    wr_en = 1; wr_idx = 3'd0; wr_data = 4'h9; wr_mask = '0; wr_valid = 1;
    srch = 1; key = 4'h9;
    @(negedge clk);
    wr_en = 0; srch = 0;
    check("R9 search during write", 8'b0000_0010);
    m_d[0] = 4'h9; m_m[0] = '0; m_v[0] = 1;
    search(4'h9, "R9 after write");

    // R10 overwrite one entry, others intact
    wr(1, 4'h4, '0, 1);
    search(4'h9, "R10 overwrite neighbours kept");
    search(4'h4, "R10 overwrite new value");

    // R1 reset mid-run clears table
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    check("R1 reset clears outputs", '0);
    search(4'h9, "R1 reset clears valid");

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule